// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is the serial slave front end of a clock/calendar device. It decodes framed serial transfers into reads and writes of a 128-location register space (eight address bits, the top one giving the direction): fifteen timekeeping bytes, a control byte, a status byte supplied from outside, a charger configuration byte and a 96-byte user RAM. The serial pins run in either a four-wire SPI style or a 3-wire style where data in and data out are joined on one wire outside the block.

All serial inputs are brought into the system clock domain through short synchronisers and all edge detection happens there, so the serial clock must be several times slower than `clk`. Every finished data byte raises a one-cycle access strobe with the byte's address, which a neighbouring alarm block uses to clear its request flags. The control byte is broken out as write-protect, 1 Hz enable and alarm-enable outputs, and the charger byte is decoded into a single enable.

Top module: `serRegPort`

## Requirements
- R1: `spiSel` high selects SPI mode with separate `sdi` and `sdo`; low selects 3-wire mode, where the device drives the shared wire only while `sdoEn` is high.
- R2: A frame runs while `ce` is high; its first byte is the address; address bit 7 = 1 writes location bits 6:0, bit 7 = 0 reads them, so location n is read at n and written at n+80h; the direction holds for the whole frame.
- R3: In SPI mode bytes travel MSB first; the `sclk` level seen when `ce` rises is the idle level; `sdo` changes on the edge leaving the idle level and `sdi` is taken on the edge returning to it.
- R4: In 3-wire mode bytes travel LSB first, input is taken on the rising `sclk` edge and output changes on the falling edge.
- R5: `sdoEn` stays low during the address byte, during write frames and while `ce` is low; it rises when the first bit of a read byte is driven.
- R6: Each data byte advances the address; reads wrap 1Fh to 00h and 7Fh to 20h, writes wrap 9Fh to 80h and FFh to A0h.
- R7: Location 0Fh is control: bit 6 write-protect (`wpOn`), bit 2 1 Hz enable (`oneHzEn`), bits 1:0 alarm enables (`alarmEn`); its other bits read 0; it resets to 00h.
- R8: While write-protect is 1 every write is dropped, except a write to 8Fh with bit 6 = 0, which clears only write-protect.
- R9: Locations 12h–1Fh read 0; writes to 90h–9Fh have no effect; 10h reads `irqFlags` in bits 1:0 with zeros above.
- R10: Location 11h holds the charger byte, reset 00h; `trickleOn` is 1 only when bits 7:4 = 1010, bits 3:2 are 01 or 10 and bits 1:0 are not 00.
- R11: Every completed data byte gives `accStb` high for exactly one cycle with `accAddr` equal to that byte's address byte value before increment.
- R12: `ce` falling inside a byte drops that byte: no write, no strobe, and the next frame starts with a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSel | input | 1 | 1 = SPI mode, 0 = 3-wire mode |
| ce | input | 1 | Frame enable, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in (shared wire in 3-wire mode) |
| irqFlags | input | 2 | Alarm request flags shown in the status byte |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output drive enable; low means high-impedance |
| accStb | output | 1 | One-cycle strobe per completed data byte |
| accAddr | output | 8 | Address of the byte flagged by `accStb` |
| wpOn | output | 1 | Control write-protect bit |
| oneHzEn | output | 1 | Control 1 Hz enable bit |
| alarmEn | output | 2 | Control alarm enable bits |
| trickleOn | output | 1 | Decoded charger enable |

## Verification
On every cycle the assertions hold the strobe to a single cycle, keep the output enable off when `ce` is low and during write frames, keep the frame direction fixed once data starts, and keep the 1 Hz and alarm enables frozen while write-protect is set. Bit ordering in both modes, both clock polarities, the four wrap points, the reserved-zero reads, the write-protect exception, the charger decode and the mid-byte abort only show up through the bench's frames compared with its reference model.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam int BYTE_W    = 8;
  localparam int LOC_W     = 7;
  localparam int TIME_REGS = 15;
  localparam int RAM_BYTES = 96;
  localparam int SYNC_N    = 2;

  localparam logic [LOC_W-1:0] CTRL_LOC = 7'h0F;
  localparam logic [LOC_W-1:0] STAT_LOC = 7'h10;
  localparam logic [LOC_W-1:0] CHG_LOC  = 7'h11;
  localparam logic [LOC_W-1:0] CLK_END  = 7'h1F;
  localparam logic [LOC_W-1:0] RAM_LOC  = 7'h20;
  localparam logic [LOC_W-1:0] RAM_END  = LOC_W'(RAM_LOC + RAM_BYTES - 1);

  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h47;
  localparam int WP_BIT = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;

  typedef struct packed {
    logic latchBit;
    logic wrEn;
    logic loadRd;
    logic drvBit;
    logic quiet;
  } portCmd_t;

  function automatic logic [BYTE_W-1:0] stepAddr(input logic [BYTE_W-1:0] a);
    if (a[LOC_W-1:0] == CLK_END)      return {a[BYTE_W-1], {LOC_W{1'b0}}};
    else if (a[LOC_W-1:0] == RAM_END) return {a[BYTE_W-1], RAM_LOC};
    else                              return a + 8'd1;
  endfunction
endpackage

// File: rtl/serRegCtl.sv
module serRegCtl
  import serRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSel,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] rxNext,
  output portCmd_t          cmd,
  output logic              sdiS,
  output logic [BYTE_W-1:0] curAddr,
  output logic [BYTE_W-1:0] rdAddr,
  output logic              accStb,
  output logic [BYTE_W-1:0] accAddr,
  output logic              isWrite,
  output phase_t            phase,
  output logic              ceOn
);
  logic [SYNC_N-1:0] ceSh, sclkSh, sdiSh;
  logic sclkS, sclkP, ceP, cpol;
  logic [2:0] bitCnt;
  logic ceRise, sclkEdge, latchEvt, shiftEvt, byteEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSh <= '0; sclkSh <= '0; sdiSh <= '0; sclkP <= 1'b0; ceP <= 1'b0;
    end else begin
      ceSh   <= {ceSh[SYNC_N-2:0], ce};
      sclkSh <= {sclkSh[SYNC_N-2:0], sclk};
      sdiSh  <= {sdiSh[SYNC_N-2:0], sdi};
      sclkP  <= sclkSh[SYNC_N-1];
      ceP    <= ceSh[SYNC_N-1];
    end
  end

  assign ceOn     = ceSh[SYNC_N-1];
  assign sclkS    = sclkSh[SYNC_N-1];
  assign sdiS     = sdiSh[SYNC_N-1];
  assign ceRise   = ceOn && !ceP;
  assign sclkEdge = ceOn && !ceRise && (sclkS != sclkP) && (phase != PH_IDLE);
  // SPI: take data when the clock returns to idle, drive when it leaves it.
  assign latchEvt = sclkEdge && (spiSel ? (sclkS == cpol) : sclkS);
  assign shiftEvt = sclkEdge && (spiSel ? (sclkS != cpol) : !sclkS);
  assign byteEnd  = latchEvt && (bitCnt == 3'd7);

  always_comb begin
    cmd          = '0;
    cmd.quiet    = !ceOn;
    cmd.latchBit = latchEvt;
    cmd.wrEn     = byteEnd && (phase == PH_DATA) && isWrite;
    cmd.loadRd   = byteEnd && ((phase == PH_ADDR) ? !rxNext[BYTE_W-1] : !isWrite);
    cmd.drvBit   = shiftEvt && (phase == PH_DATA) && !isWrite;
    rdAddr       = (phase == PH_ADDR) ? rxNext : stepAddr(curAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; bitCnt <= '0; cpol <= 1'b0; curAddr <= '0;
      isWrite <= 1'b0; accStb <= 1'b0; accAddr <= '0;
    end else begin
      accStb <= 1'b0;
      if (!ceOn) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
      end else if (ceRise) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        cpol   <= sclkS;
      end else if (latchEvt) begin
        bitCnt <= bitCnt + 3'd1;
        if (byteEnd) begin
          if (phase == PH_ADDR) begin
            curAddr <= rxNext;
            isWrite <= rxNext[BYTE_W-1];
            phase   <= PH_DATA;
          end else begin
            curAddr <= stepAddr(curAddr);
            accStb  <= 1'b1;
            accAddr <= curAddr;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serRegDp.sv
module serRegDp
  import serRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSel,
  input  portCmd_t          cmd,
  input  logic              sdiS,
  input  logic [LOC_W-1:0]  wrLoc,
  input  logic [LOC_W-1:0]  rdLoc,
  input  logic [1:0]        irqFlags,
  output logic [BYTE_W-1:0] rxNext,
  output logic              sdo,
  output logic              sdoEn,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic              trickleOn
);
  logic [BYTE_W-1:0] timeRegs [TIME_REGS];
  logic [BYTE_W-1:0] ram [RAM_BYTES];
  logic [BYTE_W-1:0] chgQ, inSh, outSh, rdByte;
  logic [LOC_W-1:0]  rdOff, wrOff;

  assign rxNext = spiSel ? {inSh[BYTE_W-2:0], sdiS} : {sdiS, inSh[BYTE_W-1:1]};
  assign rdOff  = rdLoc - RAM_LOC;
  assign wrOff  = wrLoc - RAM_LOC;

  always_comb begin
    if (rdLoc < LOC_W'(TIME_REGS)) rdByte = timeRegs[rdLoc[3:0]];
    else if (rdLoc == CTRL_LOC)    rdByte = ctrlQ;
    else if (rdLoc == STAT_LOC)    rdByte = {6'b0, irqFlags};
    else if (rdLoc == CHG_LOC)     rdByte = chgQ;
    else if (rdLoc >= RAM_LOC)     rdByte = ram[rdOff];
    else                           rdByte = '0;
  end

  assign trickleOn = (chgQ[7:4] == 4'b1010) && (chgQ[3:2] == 2'b01 || chgQ[3:2] == 2'b10)
                     && (chgQ[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TIME_REGS; i++) timeRegs[i] <= '0;
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
      ctrlQ <= '0; chgQ <= '0; inSh <= '0; outSh <= '0; sdo <= 1'b0; sdoEn <= 1'b0;
    end else begin
      if (cmd.latchBit) inSh <= rxNext;
      if (cmd.wrEn) begin
        if (ctrlQ[WP_BIT]) begin
          if (wrLoc == CTRL_LOC && !rxNext[WP_BIT]) ctrlQ[WP_BIT] <= 1'b0;
        end else if (wrLoc < LOC_W'(TIME_REGS)) timeRegs[wrLoc[3:0]] <= rxNext;
        else if (wrLoc == CTRL_LOC)             ctrlQ <= rxNext & CTRL_MASK;
        else if (wrLoc == CHG_LOC)              chgQ  <= rxNext;
        else if (wrLoc >= RAM_LOC)              ram[wrOff] <= rxNext;
      end
      if (cmd.quiet) begin
        sdoEn <= 1'b0;
      end else if (cmd.loadRd) begin
        outSh <= rdByte;
      end else if (cmd.drvBit) begin
        sdoEn <= 1'b1;
        sdo   <= spiSel ? outSh[BYTE_W-1] : outSh[0];
        outSh <= spiSel ? {outSh[BYTE_W-2:0], 1'b0} : {1'b0, outSh[BYTE_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import serRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSel,
  input  logic        ce,
  input  logic        sclk,
  input  logic        sdi,
  input  logic [1:0]  irqFlags,
  output logic        sdo,
  output logic        sdoEn,
  output logic        accStb,
  output logic [7:0]  accAddr,
  output logic        wpOn,
  output logic        oneHzEn,
  output logic [1:0]  alarmEn,
  output logic        trickleOn
);
  portCmd_t          cmd;
  logic              sdiS, isWrite, ceOn;
  logic [BYTE_W-1:0] rxNext, curAddr, rdAddr, ctrlQ;
  phase_t            phase;

  serRegCtl u_ctl (
    .clk(clk), .rstN(rstN), .spiSel(spiSel), .ce(ce), .sclk(sclk), .sdi(sdi),
    .rxNext(rxNext), .cmd(cmd), .sdiS(sdiS), .curAddr(curAddr), .rdAddr(rdAddr),
    .accStb(accStb), .accAddr(accAddr), .isWrite(isWrite), .phase(phase), .ceOn(ceOn)
  );

  serRegDp u_dp (
    .clk(clk), .rstN(rstN), .spiSel(spiSel), .cmd(cmd), .sdiS(sdiS),
    .wrLoc(curAddr[LOC_W-1:0]), .rdLoc(rdAddr[LOC_W-1:0]), .irqFlags(irqFlags),
    .rxNext(rxNext), .sdo(sdo), .sdoEn(sdoEn), .ctrlQ(ctrlQ), .trickleOn(trickleOn)
  );

  assign wpOn    = ctrlQ[WP_BIT];
  assign oneHzEn = ctrlQ[2];
  assign alarmEn = ctrlQ[1:0];
endmodule

// File: rtl/serRegPortChk.sv
module serRegPortChk
  import serRegPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       accStb,
  input logic       wpOn,
  input logic       oneHzEn,
  input logic [1:0] alarmEn,
  input logic       sdoEn,
  input logic       isWrite,
  input phase_t     phase,
  input logic       ceOn
);
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    accStb |=> !accStb); // R11
  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    wpOn |=> $stable({oneHzEn, alarmEn})); // R8
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !isWrite); // R5
  AST_SDO_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ceOn |=> !sdoEn); // R5
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && $past(phase) == PH_DATA) |-> $stable(isWrite)); // R2
endmodule

bind serRegPort serRegPortChk u_chk (
  .clk(clk), .rstN(rstN), .accStb(accStb), .wpOn(wpOn), .oneHzEn(oneHzEn),
  .alarmEn(alarmEn), .sdoEn(sdoEn), .isWrite(isWrite), .phase(phase), .ceOn(ceOn)
);

// File: tb/serRegPort_bench.sv
`timescale 1ns/1ps
module serRegPort_bench;
  localparam int H = 8;
  logic clk = 0, rstN = 0, spiSel = 1, ce = 0, sclk = 0, sdi = 0;
  logic [1:0] irqFlags = 2'b00;
  logic sdo, sdoEn, accStb, wpOn, oneHzEn, trickleOn;
  logic [7:0] accAddr;
  logic [1:0] alarmEn;
  int checks = 0, errors = 0;
  logic cpolV = 0;

  logic [7:0] mTime [15];
  logic [7:0] mRam [96];
  logic [7:0] mCtrl, mChg;
  logic [7:0] txBuf [8];
  logic [7:0] expQ [$];
  logic [7:0] gotQ [$];

  always #5 clk = ~clk;

  serRegPort u_serRegPort (
    .clk(clk), .rstN(rstN), .spiSel(spiSel), .ce(ce), .sclk(sclk), .sdi(sdi),
    .irqFlags(irqFlags), .sdo(sdo), .sdoEn(sdoEn), .accStb(accStb), .accAddr(accAddr),
    .wpOn(wpOn), .oneHzEn(oneHzEn), .alarmEn(alarmEn), .trickleOn(trickleOn)
  );

  always @(negedge clk) if (rstN && accStb) gotQ.push_back(accAddr);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(input logic [6:0] l);
    if (l <= 7'h0E) return mTime[l];
    if (l == 7'h0F) return mCtrl;
    if (l == 7'h10) return {6'b0, irqFlags};
    if (l == 7'h11) return mChg;
    if (l >= 7'h20) return mRam[l - 7'h20];
    return 8'h00;
  endfunction

  task automatic mWrite(input logic [6:0] l, input logic [7:0] d);
    if (mCtrl[6]) begin
      if (l == 7'h0F && d[6] == 1'b0) mCtrl[6] = 1'b0;
    end else begin
      if (l <= 7'h0E) mTime[l] = d;
      else if (l == 7'h0F) mCtrl = {1'b0, d[6], 3'b000, d[2:0]};
      else if (l == 7'h11) mChg = d;
      else if (l >= 7'h20) mRam[l - 7'h20] = d;
    end
  endtask

  function automatic logic [7:0] mStep(input logic [7:0] a);
    case (a)
      8'h1F: return 8'h00;
      8'h7F: return 8'h20;
      8'h9F: return 8'h80;
      8'hFF: return 8'hA0;
      default: return a + 1;
    endcase
  endfunction

  task automatic waitH();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic doBit(input logic b, output logic g, output logic e);
    if (spiSel) begin
      sclk = ~cpolV; sdi = b; waitH(); g = sdo; e = sdoEn; sclk = cpolV; waitH();
    end else begin
      sdi = b; waitH(); g = sdo; e = sdoEn; sclk = 1; waitH(); sclk = 0;
    end
  endtask

  task automatic doByte(input logic [7:0] tx, output logic [7:0] rx, output logic anyEn);
    logic g, e;
    anyEn = 0; rx = 0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = spiSel ? 7 - i : i;
      doBit(tx[idx], g, e);
      rx[idx] = g;
      anyEn |= e;
    end
  endtask

  task automatic frameStart();
    sclk = spiSel ? cpolV : 1'b0;
    waitH(); ce = 1; waitH();
  endtask

  task automatic frameEnd();
    waitH(); ce = 0; waitH(); waitH();
  endtask

  task automatic chkStb(input string tag);
    chk(gotQ.size() == expQ.size(), {tag, " R11 strobe count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk(gotQ[i] == expQ[i], {tag, " R11 strobe addr"}, gotQ[i], expQ[i]);
    gotQ.delete(); expQ.delete();
  endtask

  task automatic writeFrame(input logic [7:0] a, input int n, input string tag);
    logic [7:0] rx, cur;
    logic en, anyEn;
    cur = a | 8'h80; anyEn = 0;
    frameStart();
    doByte(cur, rx, en); anyEn |= en;
    for (int k = 0; k < n; k++) begin
      doByte(txBuf[k], rx, en); anyEn |= en;
      expQ.push_back(cur);
      mWrite(cur[6:0], txBuf[k]);
      cur = mStep(cur);
    end
    frameEnd();
    chk(!anyEn, {tag, " R5 no drive in write frame"}, anyEn, 0);
    chkStb(tag);
  endtask

  task automatic readFrame(input logic [7:0] a, input int n, input string tag);
    logic [7:0] rx, cur;
    logic en;
    cur = a & 8'h7F;
    frameStart();
    doByte(cur, rx, en);
    chk(!en, {tag, " R5 high-Z during address"}, en, 0);
    for (int k = 0; k < n; k++) begin
      doByte(8'h00, rx, en);
      chk(en, {tag, " R5 drive during read"}, en, 1);
      chk(rx == mRead(cur[6:0]), {tag, " read data"}, rx, mRead(cur[6:0]));
      expQ.push_back(cur);
      cur = mStep(cur);
    end
    frameEnd();
    chk(!sdoEn, {tag, " R5 high-Z after ce low"}, sdoEn, 0);
    chkStb(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) mTime[i] = 0;
    for (int i = 0; i < 96; i++) mRam[i] = 0;
    mCtrl = 0; mChg = 0;
    repeat (4) @(posedge clk); #1; rstN = 1; waitH();

    chk(!sdoEn && !accStb, "R5 reset: no drive, no strobe", {sdoEn, accStb}, 0);
    chk(!wpOn && !oneHzEn && alarmEn == 0, "R7 reset control", {wpOn, oneHzEn, alarmEn}, 0);
    chk(!trickleOn, "R10 reset charger off", trickleOn, 0);

    // R1 R2 R3: SPI, idle-low clock, then idle-high clock
    spiSel = 1; cpolV = 0;
    txBuf[0] = 8'h37; writeFrame(8'h01, 1, "R3 spi pol0 write");
    readFrame(8'h01, 1, "R3 spi pol0 read");
    cpolV = 1;
    txBuf[0] = 8'hC8; txBuf[1] = 8'h5E; writeFrame(8'h03, 2, "R3 spi pol1 burst");
    readFrame(8'h01, 4, "R3 spi pol1 read");

    // R1 R4: 3-wire mode, LSB first
    spiSel = 0;
    txBuf[0] = 8'h5A; txBuf[1] = 8'hC3; writeFrame(8'h20, 2, "R4 3w write");
    readFrame(8'h20, 2, "R4 3w read");

    // R6: RAM and clock wraps, and R9 reserved locations
    spiSel = 1; cpolV = 0;
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33; writeFrame(8'hFE, 3, "R6 ram write wrap");
    readFrame(8'h7E, 3, "R6 ram read wrap");
    txBuf[0] = 8'h44; txBuf[1] = 8'h55; txBuf[2] = 8'h66; writeFrame(8'h9E, 3, "R6 R9 clock write wrap");
    readFrame(8'h1E, 3, "R6 R9 clock read wrap");
    irqFlags = 2'b10;
    readFrame(8'h0F, 4, "R9 R7 status and reserved");

    // R7 R8: write-protect
    txBuf[0] = 8'hFF; writeFrame(8'h0F, 1, "R7 control write");
    chk(wpOn && oneHzEn && alarmEn == 2'b11, "R7 control outputs", {wpOn, oneHzEn, alarmEn}, 4'hF);
    txBuf[0] = 8'h99; writeFrame(8'h01, 1, "R8 protected write");
    readFrame(8'h01, 1, "R8 protected value kept");
    txBuf[0] = 8'hC0; writeFrame(8'h0F, 1, "R8 wp stays set");
    chk(wpOn && oneHzEn && alarmEn == 2'b11, "R8 control unchanged", {wpOn, oneHzEn, alarmEn}, 4'hF);
    txBuf[0] = 8'h00; writeFrame(8'h0F, 1, "R8 wp clear");
    chk(!wpOn && oneHzEn && alarmEn == 2'b11, "R8 only wp cleared", {wpOn, oneHzEn, alarmEn}, 4'h7);
    readFrame(8'h0F, 1, "R8 control readback");

    // R10: charger decode
    txBuf[0] = 8'hA5; writeFrame(8'h11, 1, "R10 charger A5");
    chk(trickleOn, "R10 A5 enables", trickleOn, 1);
    txBuf[0] = 8'hAA; writeFrame(8'h11, 1, "R10 charger AA");
    chk(trickleOn, "R10 AA enables", trickleOn, 1);
    txBuf[0] = 8'hAD; writeFrame(8'h11, 1, "R10 charger AD");
    chk(!trickleOn, "R10 diode 11 disables", trickleOn, 0);
    txBuf[0] = 8'hA4; writeFrame(8'h11, 1, "R10 charger A4");
    chk(!trickleOn, "R10 resistor 00 disables", trickleOn, 0);
    txBuf[0] = 8'hB5; writeFrame(8'h11, 1, "R10 charger B5");
    chk(!trickleOn, "R10 wrong key disables", trickleOn, 0);

    // R12: abort in the middle of a data byte
    begin
      logic [7:0] rx; logic en, g;
      frameStart();
      doByte(8'h81, rx, en);
      for (int i = 0; i < 4; i++) doBit(1'b1, g, en);
      frameEnd();
      chkStb("R12 abort");
      readFrame(8'h01, 1, "R12 value kept after abort");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule